// File: doc/BRIEF.md
# Half-Duplex Transmit Error Monitor

This block sits beside a half-duplex Ethernet transmitter on the nibble-wide transmit clock. It watches one transmit attempt at a time and looks for four error conditions. A collision after the first 64 bytes counts as late. A frame aborts after sixteen consecutive attempts that each ended in a collision. The carrier can be missing while the block transmits. A pending frame can wait too long before it starts. Each condition sets a sticky status flag. The flags sit in a 32-bit status word and are cleared by writing ones to them. Each flag has an interrupt enable, and the enabled flags are ORed into one transmit interrupt.

The transmitter drives `tx_en` for every attempt. `col` and `crs` come from the line interface. `pending` says that a frame is queued and waiting to go. A controller reads `status`, clears flags through `wr_en`/`wr_data` and masks the interrupt with `irq_en`. When `frame_drop` pulses, the transmitter abandons the frame. Backoff timing, CRC and frame data belong to other blocks.

Top module: `hdx_tx_guard`

## Requirements
- R1: After reset, `status` is all zero and `tx_irq` and `frame_drop` are low.
- R2: A `col` in a cycle where `tx_en` is high and at least 128 nibbles (64 bytes) of the current attempt have already been sent sets status bit 22 at the next edge. A collision during nibbles 0 to 127 does not set it.
- R3: An attempt is the span of high `tx_en`, and it ends in the first cycle in which `tx_en` is low again. If 16 consecutive attempts each see a collision, then at the edge that ends the 16th attempt, status bit 21 is set and `frame_drop` goes high for exactly one cycle.
- R4: The consecutive-collision count returns to zero when an attempt ends without a collision, and also after an abort.
- R5: Any cycle with `tx_en` high and `crs` low sets status bit 20 at the next edge.
- R6: Status bit 19 is set at the edge that ends the 8192nd consecutive cycle with `pending` high, `tx_en` low and `no_defer` low. After 8191 such cycles it is still clear.
- R7: While `no_defer` is high, bit 19 never sets, however long the frame waits.
- R8: While `full_duplex` is high, no status bit can become set, and the attempt, collision and defer counters are held at zero.
- R9: A write (`wr_en` high) clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value. Without a write, a flag never falls.
- R10: If a flag's set condition and its clear happen in the same cycle, the flag ends up set.
- R11: `tx_irq` is high exactly when some status bit is set and its enable is set. The enables map as follows: `irq_en[3]` to bit 22, `irq_en[2]` to bit 21, `irq_en[1]` to bit 20 and `irq_en[0]` to bit 19. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 = full duplex, all checks disabled |
| no_defer | input | 1 | 1 = skip the deferral time check |
| tx_en | input | 1 | Transmit enable, high during an attempt |
| col | input | 1 | Collision from the line |
| crs | input | 1 | Carrier sense from the line |
| pending | input | 1 | A frame is queued and waiting |
| wr_en | input | 1 | Status clear write strobe |
| wr_data | input | 32 | Write data, 1 clears the matching status bit |
| irq_en | input | 4 | Per-flag interrupt enables |
| status | output | 32 | Status word, flags at bits 22..19 |
| frame_drop | output | 1 | One-cycle pulse to abandon the current frame |
| tx_irq | output | 1 | Combined transmit interrupt |

## Verification
The hardest condition to reach is the abort. It needs sixteen back-to-back attempts that each collide, with no clean attempt in between. The directed stimulus therefore drives short colliding attempts in a tight loop. It also drives a run of ten colliding attempts, one clean attempt and ten more, to show that the count restarted. The late-collision boundary is reached by holding `tx_en` for exactly 127 and then 128 nibbles before raising `col`. The deferral limit is reached by a single 8192-cycle wait. Random traffic with long attempts and sparse collisions is then compared every cycle against a bench model.

// File: rtl/hdx_guard_pkg.sv
package hdx_guard_pkg;
   localparam int FLAG_N    = 4;
   localparam int IDX_DEFER = 0;
   localparam int IDX_NOCRS = 1;
   localparam int IDX_ABORT = 2;
   localparam int IDX_LATE  = 3;
   typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/hdx_frame_track.sv
// Tracks one transmit attempt: nibble position, collision history, carrier.
module hdx_frame_track #(
   parameter int LATE_NIBBLES = 128,
   parameter int ABORT_LIMIT  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half,
   input  logic tx_en,
   input  logic col,
   input  logic crs,
   output logic late_evt,
   output logic abort_evt,
   output logic nocrs_evt
);
   localparam int NW = $clog2(LATE_NIBBLES + 1);
   localparam int CW = $clog2(ABORT_LIMIT + 1);

   logic [NW-1:0] nib_cnt;
   logic [CW-1:0] coll_cnt;
   logic          tx_q;
   logic          col_seen;
   logic          frame_end;
   logic          abort_hit;

   assign frame_end = tx_q & ~tx_en;
   assign abort_hit = frame_end & col_seen & (coll_cnt == CW'(ABORT_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nib_cnt  <= '0;
         coll_cnt <= '0;
         tx_q     <= 1'b0;
         col_seen <= 1'b0;
      end else if (!half) begin
         nib_cnt  <= '0;
         coll_cnt <= '0;
         tx_q     <= 1'b0;
         col_seen <= 1'b0;
      end else begin
         tx_q <= tx_en;
         if (tx_en) begin
            if (nib_cnt != NW'(LATE_NIBBLES)) nib_cnt <= nib_cnt + 1'b1;
            if (col) col_seen <= 1'b1;
         end else begin
            nib_cnt <= '0;
         end
         if (frame_end) begin
            col_seen <= 1'b0;
            if (!col_seen || abort_hit) coll_cnt <= '0;
            else                        coll_cnt <= coll_cnt + 1'b1;
         end
      end
   end

   assign late_evt  = half & tx_en & col & (nib_cnt == NW'(LATE_NIBBLES));
   assign abort_evt = half & abort_hit;
   assign nocrs_evt = half & tx_en & ~crs;
endmodule

// File: rtl/hdx_defer_timer.sv
// Counts consecutive waiting cycles of a pending frame.
module hdx_defer_timer #(
   parameter int LIMIT = 8192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic pending,
   input  logic tx_en,
   output logic exceed_evt
);
   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt;
   logic         waiting;

   assign waiting = armed & pending & ~tx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!waiting)          cnt <= '0;
      else if (cnt != W'(LIMIT))  cnt <= cnt + 1'b1;
   end

   assign exceed_evt = waiting & (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/hdx_flag_bank.sv
// Sticky flags with write-one-to-clear; parameter picks set/clear priority.
module hdx_flag_bank #(
   parameter int N        = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] & ~clr[i]) | set_evt[i];
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] | set_evt[i]) & ~clr[i];
         end
      end
   end
endmodule

// File: rtl/hdx_tx_guard.sv
module hdx_tx_guard
   import hdx_guard_pkg::*;
#(
   parameter int LATE_BYTES     = 64,
   parameter int NIB_PER_BYTE   = 2,
   parameter int ABORT_LIMIT    = 16,
   parameter int DEFER_LIMIT    = 8192,
   parameter bit SET_WINS       = 1'b1,
   parameter int STATUS_W       = 32,
   parameter int STATUS_LSB     = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                full_duplex,
   input  logic                no_defer,
   input  logic                tx_en,
   input  logic                col,
   input  logic                crs,
   input  logic                pending,
   input  logic                wr_en,
   input  logic [STATUS_W-1:0] wr_data,
   input  logic [FLAG_N-1:0]   irq_en,
   output logic [STATUS_W-1:0] status,
   output logic                frame_drop,
   output logic                tx_irq
);
   localparam int LATE_NIBBLES = LATE_BYTES * NIB_PER_BYTE;

   if (STATUS_LSB + FLAG_N > STATUS_W) begin : g_bad_field
      $error("hdx_tx_guard: flag field does not fit the status word");
   end
   if (ABORT_LIMIT < 2) begin : g_bad_abort
      $error("hdx_tx_guard: ABORT_LIMIT must be at least 2");
   end
   if (DEFER_LIMIT < 2) begin : g_bad_defer
      $error("hdx_tx_guard: DEFER_LIMIT must be at least 2");
   end
   if (LATE_NIBBLES < 1) begin : g_bad_late
      $error("hdx_tx_guard: late window must be positive");
   end

   logic      half;
   logic      late_evt, abort_evt, nocrs_evt, defer_evt;
   flag_vec_t set_vec, clr_vec, flags;

   assign half = ~full_duplex;

   hdx_frame_track #(
      .LATE_NIBBLES (LATE_NIBBLES),
      .ABORT_LIMIT  (ABORT_LIMIT)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .half      (half),
      .tx_en     (tx_en),
      .col       (col),
      .crs       (crs),
      .late_evt  (late_evt),
      .abort_evt (abort_evt),
      .nocrs_evt (nocrs_evt)
   );

   hdx_defer_timer #(
      .LIMIT (DEFER_LIMIT)
   ) u_defer (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed      (half & ~no_defer),
      .pending    (pending),
      .tx_en      (tx_en),
      .exceed_evt (defer_evt)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[IDX_LATE]  = late_evt;
      set_vec[IDX_ABORT] = abort_evt;
      set_vec[IDX_NOCRS] = nocrs_evt;
      set_vec[IDX_DEFER] = defer_evt;
      clr_vec            = wr_en ? wr_data[STATUS_LSB +: FLAG_N] : '0;
   end

   hdx_flag_bank #(
      .N        (FLAG_N),
      .SET_WINS (SET_WINS)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec),
      .clr     (clr_vec),
      .flags   (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_drop <= 1'b0;
      else        frame_drop <= abort_evt;
   end

   always_comb begin
      status                      = '0;
      status[STATUS_LSB +: FLAG_N] = flags;
   end

   assign tx_irq = |(flags & irq_en);
endmodule

// File: rtl/hdx_tx_guard_chk.sv
module hdx_tx_guard_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        full_duplex,
   input logic        no_defer,
   input logic        wr_en,
   input logic [31:0] status,
   input logic [3:0]  irq_en,
   input logic        frame_drop,
   input logic        tx_irq
);
   // R11: interrupt only with an enabled, set flag
   a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> ((status[22:19] & irq_en) != 4'b0));

   // R8: no flag rises after a full-duplex cycle
   a_r8_fd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      full_duplex |=> ((status[22:19] & ~$past(status[22:19])) == 4'b0));

   // R9: without a write no flag falls
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((~status[22:19] & $past(status[22:19])) == 4'b0));

   // R3: drop pulse lasts one cycle and comes with the abort flag
   a_r3_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |=> !frame_drop);
   a_r3_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> status[21]);

   // R7: defer flag cannot rise after a no_defer cycle
   a_r7_no_defer: assert property (@(posedge clk) disable iff (!rst_n)
      no_defer |=> !$rose(status[19]));
endmodule

bind hdx_tx_guard hdx_tx_guard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .full_duplex (full_duplex),
   .no_defer    (no_defer),
   .wr_en       (wr_en),
   .status      (status),
   .irq_en      (irq_en),
   .frame_drop  (frame_drop),
   .tx_irq      (tx_irq)
);

// File: tb/hdx_tx_guard_test.sv
`timescale 1ns/1ps
module hdx_tx_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_duplex = 1'b0, no_defer = 1'b0, tx_en = 1'b0, col = 1'b0;
   logic        crs = 1'b1, pending = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [3:0]  irq_en = 4'hF;
   logic [31:0] status;
   logic        frame_drop, tx_irq;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   hdx_tx_guard uut (
      .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .no_defer(no_defer),
      .tx_en(tx_en), .col(col), .crs(crs), .pending(pending), .wr_en(wr_en),
      .wr_data(wr_data), .irq_en(irq_en), .status(status),
      .frame_drop(frame_drop), .tx_irq(tx_irq));

   // ---------------- bench model built from the requirements ----------------
   int       m_nib, m_ccnt, m_dcnt;
   bit       m_txq, m_colseen, m_drop;
   bit [3:0] m_flags;   // [3]=late [2]=abort [1]=no carrier [0]=defer
   bit       e_late, e_abort, e_nocrs, e_def, e_end, e_half, e_wait;
   bit [3:0] e_set, e_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_nib = 0; m_ccnt = 0; m_dcnt = 0; m_txq = 0; m_colseen = 0;
         m_drop = 0; m_flags = 0;
      end else begin
         e_half  = !full_duplex;
         e_late  = e_half && tx_en && col && (m_nib >= 128);
         e_nocrs = e_half && tx_en && !crs;
         e_end   = m_txq && !tx_en;
         e_abort = e_half && e_end && m_colseen && (m_ccnt == 15);
         e_wait  = e_half && !no_defer && pending && !tx_en;
         e_def   = e_wait && (m_dcnt == 8191);
         e_set   = {e_late, e_abort, e_nocrs, e_def};
         e_clr   = wr_en ? wr_data[22:19] : 4'b0;
         m_flags = (m_flags & ~e_clr) | e_set;
         m_drop  = e_abort;
         m_dcnt  = e_wait ? ((m_dcnt < 8192) ? m_dcnt + 1 : m_dcnt) : 0;
         if (!e_half) begin
            m_nib = 0; m_ccnt = 0; m_txq = 0; m_colseen = 0;
         end else begin
            if (e_end) begin
               m_ccnt    = (!m_colseen || e_abort) ? 0 : m_ccnt + 1;
               m_colseen = 0;
            end
            if (tx_en) begin
               if (m_nib < 128) m_nib = m_nib + 1;
               if (col) m_colseen = 1;
            end else m_nib = 0;
            m_txq = tx_en;
         end
      end
   end

   function automatic logic [31:0] exp_status(input bit [3:0] f);
      logic [31:0] s = '0;
      s[22:19] = f;
      return s;
   endfunction

   function automatic logic exp_irq(input bit [3:0] f, input logic [3:0] en);
      return |(f & en);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input int len, input int col_at);
      tx_en = 1'b1;
      for (int i = 0; i < len; i++) begin
         col = (i == col_at);
         step();
      end
      tx_en = 1'b0; col = 1'b0;
      step();
   endtask

   task automatic clear_all();
      wr_en = 1'b1; wr_data = '1; step(); wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0745));
      step(3);
      // R1 reset state
      check("R1 status after reset", status, 32'h0);
      check("R1 irq after reset", {31'b0, tx_irq}, 32'h0);
      check("R1 drop after reset", {31'b0, frame_drop}, 32'h0);
      rst_n = 1'b1;
      step();

      // R2 late collision boundary
      tx_en = 1'b1;
      step(127);
      col = 1'b1; step();
      check("R2 collision at nibble 127 not late", status, 32'h0);
      step();
      check("R2 collision at nibble 128 is late", status, 32'h0040_0000);
      check("R11 irq from late flag", {31'b0, tx_irq}, 32'h1);
      tx_en = 1'b0; col = 1'b0; step();
      frame(2, -1);
      wr_en = 1'b1; wr_data = 32'h0040_0000; step(); wr_en = 1'b0;
      check("R9 write one clears bit 22", status, 32'h0);

      // R3 abort after 16 colliding attempts
      for (int k = 0; k < 15; k++) frame(3, 1);
      check("R3 no abort after 15", status, 32'h0);
      frame(3, 1);
      check("R3 abort flag at 16", status, 32'h0020_0000);
      check("R3 drop pulse", {31'b0, frame_drop}, 32'h1);
      step();
      check("R3 drop one cycle", {31'b0, frame_drop}, 32'h0);
      clear_all();
      // R4 count restarts after abort and after a clean attempt
      for (int k = 0; k < 10; k++) frame(3, 0);
      frame(4, -1);
      for (int k = 0; k < 10; k++) frame(3, 2);
      check("R4 clean attempt restarts count", status, 32'h0);
      frame(4, -1);

      // R5 and R10 no carrier, set beats clear
      tx_en = 1'b1; crs = 1'b0; step();
      check("R5 no carrier sets bit 20", status, 32'h0010_0000);
      wr_en = 1'b1; wr_data = 32'h0010_0000; step();
      check("R10 set wins over clear", status, 32'h0010_0000);
      tx_en = 1'b0; crs = 1'b1; step(); wr_en = 1'b0;
      check("R9 clear without set", status, 32'h0);
      tx_en = 1'b1; crs = 1'b0; step(); tx_en = 1'b0; crs = 1'b1; step();
      wr_en = 1'b1; wr_data = ~32'h0010_0000; step(); wr_en = 1'b0;
      check("R9 zero bit keeps flag", status, 32'h0010_0000);

      // R11 masking
      irq_en = 4'b1101; #1;
      check("R11 masked flag gives no irq", {31'b0, tx_irq}, 32'h0);
      irq_en = 4'b0010; #1;
      check("R11 enabled flag gives irq", {31'b0, tx_irq}, 32'h1);
      irq_en = 4'hF;
      clear_all();

      // R8 full duplex suppresses everything
      full_duplex = 1'b1; pending = 1'b1;
      tx_en = 1'b1; col = 1'b1; crs = 1'b0;
      step(300);
      tx_en = 1'b0; col = 1'b0; crs = 1'b1; pending = 1'b1;
      step(9000);
      check("R8 no flags in full duplex", status, 32'h0);
      pending = 1'b0; step(); full_duplex = 1'b0; step();

      // R6 defer limit
      pending = 1'b1; step(8191);
      check("R6 no defer flag at 8191", status, 32'h0);
      step();
      check("R6 defer flag at 8192", status, 32'h0008_0000);
      pending = 1'b0; clear_all();

      // R7 no_defer suppresses check
      no_defer = 1'b1; pending = 1'b1; step(8300);
      check("R7 no defer flag with no_defer", status, 32'h0);
      pending = 1'b0; no_defer = 1'b0; step();

      // random traffic compared with the model
      for (int i = 0; i < 4000; i++) begin
         check("R2 R3 R5 R8 R9 random status", status, exp_status(m_flags));
         check("R11 random irq", {31'b0, tx_irq}, {31'b0, exp_irq(m_flags, irq_en)});
         check("R3 random drop", {31'b0, frame_drop}, {31'b0, m_drop});
         if (tx_en) tx_en = ($urandom_range(0, 99) != 0);
         else       tx_en = ($urandom_range(0, 3) == 0);
         col         = tx_en && ($urandom_range(0, 7) == 0);
         crs         = ($urandom_range(0, 31) != 0);
         pending     = ($urandom_range(0, 1) == 1);
         no_defer    = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 199) == 0) full_duplex = ~full_duplex;
         wr_en       = ($urandom_range(0, 9) == 0);
         wr_data     = $urandom();
         if ($urandom_range(0, 19) == 0) irq_en = 4'($urandom());
         step();
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule